// File: doc/BRIEF.md
# I2C Register-Read Responder with CRC-8

This block is an I2C target that answers register reads from a register file outside the block. The register file is reached through a parallel address/data port. The controller first writes one byte, which becomes the register pointer. It then reads from that pointer, either after a repeated start or after a stop and a fresh start. During a block read the pointer steps by one after every data byte, so consecutive reads walk the register file.

When the CRC enable input is high, every data byte is followed by a CRC-8 byte that the responder sends. The CRC uses polynomial 0x07 with a zero seed. For the first data byte, the CRC covers every byte seen since the CRC was last cleared: the write address, the pointer byte, the read address and the data. For every later data byte it covers the data byte alone. The accumulator clears after each data byte and on every stop. The controller rejects a bad CRC by answering NACK, which drops the responder back to idle. With CRC disabled, no CRC byte is inserted and the controller's ACK or NACK after each data byte decides whether the read goes on.

SCL and SDA pass through two-stage synchronizers. Data is sampled on rising SCL. SDA is driven only as an open-drain pull-down, and it changes only after SCL has been seen low.

Top module: `i2c_crc_responder`

## Requirements
- R1: After reset the responder does not pull SDA and the register pointer `rf_addr` is 0.
- R2: An address byte whose upper 7 bits equal the parameter `DEV_ID` is acknowledged (SDA pulled low in the ninth clock). Any other address gets no acknowledge, and every later byte is ignored until the next start.
- R3: The byte written after the address with R/W bit (bit 0) = 0 is acknowledged and becomes the pointer shown on `rf_addr`.
- R4: After an address with R/W = 1, the responder sends `rf_data` for the current pointer, MSB first. This works whether the read follows a repeated start or a stop and a new start.
- R5: With CRC enabled and a repeated start, the CRC byte after the first data byte is the CRC-8 (polynomial 0x07, seed 0, MSB first) of the four bytes: write address, pointer byte, read address, data.
- R6: A stop clears the CRC. When a stop separates the pointer write from the read, the first CRC covers only the read address byte and the data byte.
- R7: The pointer increments by one after each data byte. In a block read, every CRC after the first covers only its own data byte.
- R8: A NACK from the controller on a CRC byte returns the responder to idle. It drives nothing more until the next start.
- R9: With CRC disabled, data bytes follow one another directly while the controller ACKs. After a NACK the responder releases SDA and goes idle.
- R10: The responder starts or stops pulling SDA only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| sda_pull | output | 1 | 1 = pull SDA low (open-drain drive) |
| crc_on | input | 1 | 1 = append a CRC byte after each data byte |
| rf_addr | output | AW | Register pointer to the register file |
| rf_data | input | 8 | Register file data at `rf_addr` |

## Verification
The assertions watch the following on every cycle:
- SDA drive begins only while the synchronized SCL is low.
- A stop always leaves the responder idle, released and with a cleared CRC.
- The responder is released whenever it is idle.
- The pointer changes only by a load from the pointer byte or a step of one.
- A NACK on a CRC byte forces idle.

The byte contents can only be shown by the bench's bus transactions: which bytes each CRC covers under a repeated start, under a stop-separated read and under a block read, and the data order and pointer stepping. The same holds for the ignoring of a foreign address and for the behaviour with CRC off.

// File: rtl/i2c_crc_responder.sv
module i2c_crc_responder #(
  parameter logic [6:0] DEV_ID = 7'h2A,
  parameter int         AW     = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          sda_pull,
  input  logic          crc_on,
  output logic [AW-1:0] rf_addr,
  input  logic [7:0]    rf_data
);

  localparam logic [7:0] POLY = 8'h07;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_REG, S_DATA, S_CRC} st_t;

  logic scl_m, scl_s, scl_d, sda_m, sda_s, sda_d;
  st_t  st;
  logic [3:0] cnt;
  logic [7:0] rx, tx, crc;
  logic ack_n;
  logic [AW-1:0] ptr;

  wire rise     = scl_s & ~scl_d;
  wire fall     = ~scl_s & scl_d;
  wire start_c  = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_c   = scl_s & scl_d & ~sda_d & sda_s;
  wire hit      = (rx[7:1] == DEV_ID);
  wire slot_end = fall && (cnt == 4'd9);
  wire ptr_ld   = slot_end && (st == S_REG);

  assign rf_addr = ptr;

  function automatic logic [7:0] crc_step(input logic [7:0] c, input logic b);
    return {c[6:0], 1'b0} ^ ((c[7] ^ b) ? POLY : 8'h00);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_m <= 1'b1; scl_s <= 1'b1; scl_d <= 1'b1;
      sda_m <= 1'b1; sda_s <= 1'b1; sda_d <= 1'b1;
      st <= S_IDLE; cnt <= '0; rx <= '0; tx <= '0; crc <= '0;
      ack_n <= 1'b1; ptr <= '0; sda_pull <= 1'b0;
    end else begin
      scl_m <= scl_in; scl_s <= scl_m; scl_d <= scl_s;
      sda_m <= sda_in; sda_s <= sda_m; sda_d <= sda_s;
      if (start_c) begin
        st <= S_ADDR; cnt <= '0; sda_pull <= 1'b0;
      end else if (stop_c) begin
        st <= S_IDLE; cnt <= '0; sda_pull <= 1'b0; crc <= '0;
      end else if (st != S_IDLE) begin
        if (rise) begin
          if (cnt < 4'd8) begin
            rx <= {rx[6:0], sda_s};
            if (st != S_CRC) crc <= crc_step(crc, sda_s);
          end else begin
            ack_n <= sda_s;
          end
          if (cnt < 4'd9) cnt <= cnt + 4'd1;
        end
        if (fall && cnt >= 4'd1 && cnt <= 4'd7 && (st == S_DATA || st == S_CRC)) begin
          sda_pull <= ~tx[6];
          tx <= {tx[6:0], 1'b0};
        end
        if (fall && cnt == 4'd8) begin
          case (st)
            S_ADDR: sda_pull <= hit;
            S_REG:  sda_pull <= 1'b1;
            S_DATA: begin sda_pull <= 1'b0; ptr <= ptr + 1'b1; end
            default: sda_pull <= 1'b0;
          endcase
        end
        if (slot_end) begin
          cnt <= '0;
          case (st)
            S_ADDR: begin
              if (!hit) begin
                st <= S_IDLE; crc <= '0; sda_pull <= 1'b0;
              end else if (rx[0]) begin
                st <= S_DATA; tx <= rf_data; sda_pull <= ~rf_data[7];
              end else begin
                st <= S_REG; sda_pull <= 1'b0;
              end
            end
            S_REG: begin
              ptr <= AW'(rx); st <= S_IDLE; sda_pull <= 1'b0;
            end
            S_DATA: begin
              crc <= '0;
              if (crc_on) begin
                st <= S_CRC; tx <= crc; sda_pull <= ~crc[7];
              end else if (!ack_n) begin
                tx <= rf_data; sda_pull <= ~rf_data[7];
              end else begin
                st <= S_IDLE; sda_pull <= 1'b0;
              end
            end
            S_CRC: begin
              if (!ack_n) begin
                st <= S_DATA; tx <= rf_data; sda_pull <= ~rf_data[7];
              end else begin
                st <= S_IDLE; sda_pull <= 1'b0; crc <= '0;
              end
            end
            default: st <= S_IDLE;
          endcase
        end
      end
    end
  end

  p_drive_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_s);

  p_stop_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> (st == S_IDLE) && !sda_pull && (crc == 8'h00));

  p_idle_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_pull);

  p_crc_nack_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_end && st == S_CRC && ack_n && !start_c && !stop_c) |=> (st == S_IDLE));

  p_ptr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr != $past(ptr)) |-> ($past(ptr_ld) || ptr == AW'($past(ptr) + 1'b1)));

endmodule

// File: tb/i2c_crc_responder_test.sv
module i2c_crc_responder_test;
  localparam logic [6:0] DEV = 7'h2A;
  localparam int Q = 10;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, scl, m_low, crc_on;
  logic sda_pull;
  logic [7:0] rf_addr, rf_data;
  wire sda_line = ~(m_low | sda_pull);

  int checks = 0, fails = 0, viol = 0;
  bit done = 0;
  logic prev_pull = 1'b0, prev_scl = 1'b1;

  function automatic logic [7:0] rf_val(input logic [7:0] a);
    return {a[3:0], a[7:4]} ^ 8'h3C;
  endfunction

  assign rf_data = rf_val(rf_addr);

  i2c_crc_responder #(.DEV_ID(DEV), .AW(8)) uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
    .sda_pull(sda_pull), .crc_on(crc_on), .rf_addr(rf_addr), .rf_data(rf_data));

  always @(posedge clk) begin
    #1;
    if (rst_n && sda_pull != prev_pull && scl && prev_scl) viol++;
    prev_pull = sda_pull;
    prev_scl  = scl;
  end

  function automatic logic [7:0] crc_add(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] r = c;
    for (int i = 7; i >= 0; i--) begin
      logic fb = r[7] ^ b[i];
      r = {r[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return r;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put_bit(input logic b, output logic seen);
    m_low = ~b; tick(2*Q);
    scl = 1'b1; tick(Q);
    seen = sda_line; tick(Q);
    scl = 1'b0;
  endtask

  task automatic bus_start();
    m_low = 1'b0; tick(Q); scl = 1'b1; tick(Q);
    m_low = 1'b1; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_low = 1'b1; tick(Q); scl = 1'b1; tick(Q); m_low = 1'b0; tick(Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic nack);
    logic s;
    for (int i = 7; i >= 0; i--) put_bit(b[i], s);
    put_bit(1'b1, nack);
  endtask

  task automatic rd_byte(input logic give_nack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin put_bit(1'b1, s); d[i] = s; end
    put_bit(give_nack, s);
  endtask

  task automatic set_ptr(input logic [7:0] p);
    logic n;
    bus_start();
    wr_byte({DEV, 1'b0}, n); chk("R2 write address ack", n, 0);
    wr_byte(p, n);           chk("R3 pointer byte ack", n, 0);
    tick(Q);
    chk("R3 pointer loaded", rf_addr, p);
  endtask

  task automatic t_reset();
    chk("R1 sda released", sda_pull, 0);
    chk("R1 pointer zero", rf_addr, 0);
  endtask

  task automatic t_mismatch();
    logic n;
    bus_start();
    wr_byte({7'h11, 1'b0}, n); chk("R2 foreign address not acked", n, 1);
    wr_byte(8'h77, n);         chk("R2 later byte ignored", n, 1);
    tick(Q);
    chk("R2 pointer untouched", rf_addr, 0);
    chk("R2 sda released", sda_pull, 0);
    bus_stop();
  endtask

  task automatic t_single_rstart();
    logic n; logic [7:0] d, c, e;
    set_ptr(8'h10);
    bus_start();
    wr_byte({DEV, 1'b1}, n); chk("R2 read address ack", n, 0);
    rd_byte(1'b0, d);        chk("R4 data after repeated start", d, rf_val(8'h10));
    rd_byte(1'b1, c);
    e = crc_add(crc_add(crc_add(crc_add(8'h00, {DEV, 1'b0}), 8'h10), {DEV, 1'b1}), rf_val(8'h10));
    chk("R5 crc over four bytes", c, e);
    chk("R7 pointer stepped", rf_addr, 8'h11);
    bus_stop();
  endtask

  task automatic t_read_after_stop();
    logic n; logic [7:0] d, c;
    set_ptr(8'h20);
    bus_stop();
    bus_start();
    wr_byte({DEV, 1'b1}, n); chk("R4 read address ack after stop", n, 0);
    rd_byte(1'b0, d);        chk("R4 data after stop", d, rf_val(8'h20));
    rd_byte(1'b1, c);
    chk("R6 crc restarts after stop", c, crc_add(crc_add(8'h00, {DEV, 1'b1}), rf_val(8'h20)));
    bus_stop();
  endtask

  task automatic t_block();
    logic n; logic [7:0] d, c, e;
    set_ptr(8'h30);
    bus_start();
    wr_byte({DEV, 1'b1}, n);
    for (int k = 0; k < 3; k++) begin
      rd_byte(1'b0, d);
      chk("R7 block data", d, rf_val(8'h30 + k[7:0]));
      rd_byte(k == 2, c);
      if (k == 0)
        e = crc_add(crc_add(crc_add(crc_add(8'h00, {DEV, 1'b0}), 8'h30), {DEV, 1'b1}), d);
      else
        e = crc_add(8'h00, d);
      chk("R7 block crc", c, e);
    end
    chk("R7 pointer after block", rf_addr, 8'h33);
    bus_stop();
  endtask

  task automatic t_crc_nack();
    logic n; logic [7:0] d, c;
    set_ptr(8'h40);
    bus_start();
    wr_byte({DEV, 1'b1}, n);
    rd_byte(1'b0, d);
    rd_byte(1'b1, c);
    rd_byte(1'b0, d);
    chk("R8 idle after crc nack", d, 8'hFF);
    chk("R8 sda released", sda_pull, 0);
    bus_stop();
  endtask

  task automatic t_no_crc();
    logic n; logic [7:0] d;
    crc_on = 1'b0;
    set_ptr(8'h50);
    bus_start();
    wr_byte({DEV, 1'b1}, n);
    for (int k = 0; k < 3; k++) begin
      rd_byte(k == 2, d);
      chk("R9 data without crc", d, rf_val(8'h50 + k[7:0]));
    end
    rd_byte(1'b1, d);
    chk("R9 released after nack", d, 8'hFF);
    bus_stop();
    crc_on = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; scl = 1'b1; m_low = 1'b0; crc_on = 1'b1;
    tick(5); rst_n = 1'b1; tick(3);
    t_reset();
    t_mismatch();
    t_single_rstart();
    t_read_after_stop();
    t_block();
    t_crc_nack();
    t_no_crc();
    chk("R10 sda changes only with scl low", viol, 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule